// File: doc/BRIEF.md
# Tiled Integer Matrix-Multiply Engine

The engine multiplies two square integer tiles, A and B, held in local flop buffers, and writes the result into a local C tile. Operands are loaded over a 64-bit port, and each load word carries two operands, one in each 32-bit lane. Each operand is fetched from the port once. After that the multiply-accumulate pipeline reads it from the local buffer as often as the product needs it. The pipeline takes one operand pair per clock. It walks the rows of A in the outer loop, the columns of B in the middle loop and the reduction index in the inner loop.

A product larger than one tile is built from block-wise pieces. The caller loads one A tile and the matching B tile for a reduction step and starts a pass. On the first pass the C tile is cleared. On each later pass the accumulate mode is set, so that the new tile product is added to the C values already held. After the final pass, C equals the untiled product for that output block. A `start` pulse launches a pass. `busy` covers the run, and a one-cycle `done` marks the point from which C can be read by row and column.

Top module: `mm_tile_engine`

## Requirements
- R1: With `accum_mode`=0 at start, each C[i][j] (row-major index i*4+j) becomes the sum over k=0..3 of A[i][k]*B[k][j], and values left by earlier passes are discarded.
- R2: A load with `ld_valid`=1 writes tile `ld_sel` (0 = A, 1 = B) at word `ld_addr`=w. Bits [15:0] go to row-major element 2w and bits [47:32] go to element 2w+1. Bits [31:16] and [63:48] are ignored.
- R3: Operands are 16-bit two's complement. `rd_data` is the exact 40-bit two's-complement result, including the full-scale cases ±32768 x ±32768 summed over four terms.
- R4: With `accum_mode`=1 at start, the tile product is added to the C values already held. Two passes over the two k-tiles of an 8x8 product then give the untiled result for that C block.
- R5: The pipeline accepts one operand pair per clock. `done` first rises exactly 65 clock edges (tile size cubed plus one) after the edge that samples `start`.
- R6: A `start` sampled while idle raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` is high, and it is low in that cycle.
- R7: `done` is high for exactly one cycle per pass.
- R8: A `start` pulse while `busy` is ignored: no extra pass and no change to the C values produced.
- R9: Loads while `busy` are ignored. The operands used by the running pass and by later passes are unchanged.
- R10: After reset, `busy`=0, `done`=0 and every C element reads 0.
- R11: `rd_data` shows, in the same cycle, the C element at row `rd_row` and column `rd_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load word strobe |
| ld_sel | input | 1 | Target tile: 0 = A, 1 = B |
| ld_addr | input | 3 | Word index within the tile |
| ld_data | input | 64 | Two packed operands, one per 32-bit lane |
| start | input | 1 | Launch a tile pass |
| accum_mode | input | 1 | 1 = add into the existing C, 0 = clear C first |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| rd_row | input | 2 | Result row |
| rd_col | input | 2 | Result column |
| rd_data | output | 40 | Signed C element |

## Verification
Some properties are checked by assertions on every cycle. These cover the start-to-busy step, the single-cycle `done`, the fact that `busy` is low while `done` is high, the mode held across a pass, and the fact that every non-first term in the pipeline directly follows another term. The arithmetic has to be shown by the bench scenarios. That covers the four-term dot products, lane packing with garbage in the upper lanes, full-scale signed values, carrying C across two k-tiles, and the exact latency. Only a full pass can show that loads and `start` pulses arriving mid-run are ignored.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int unsigned LD_W   = 64;
    localparam int unsigned LANE_W = 32;
    localparam int unsigned LANES  = LD_W / LANE_W;
endpackage

// File: rtl/mm_opbuf.sv
// Local operand tile: written two elements per load word, read one element per cycle.
module mm_opbuf
    import mm_pkg::*;
#(
    parameter int T   = 4,
    parameter int OPW = 16,
    localparam int NEL   = T * T,
    localparam int WORDS = NEL / LANES,
    localparam int WAW   = $clog2(WORDS),
    localparam int IW    = $clog2(NEL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [WAW-1:0]        waddr,
    input  logic [LD_W-1:0]       wdata,
    input  logic [IW-1:0]         rd_idx,
    output logic signed [OPW-1:0] rd_op
);
    typedef struct packed {
        logic [NEL-1:0][OPW-1:0] mem;
    } buf_s;

    buf_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int l = 0; l < int'(LANES); l++) begin
                st_d.mem[IW'(int'(LANES) * int'(waddr) + l)] = wdata[l*LANE_W +: OPW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_op = signed'(st_q.mem[rd_idx]);
endmodule

// File: rtl/mm_seq.sv
// Pass sequencer: i outer, j middle, k inner; one issue per clock.
module mm_seq #(
    parameter int T = 4,
    localparam int NOPS = T * T * T,
    localparam int CW   = $clog2(NOPS + 1),
    localparam int KW   = $clog2(T)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          accum_mode,
    output logic          busy,
    output logic          done,
    output logic          acc_mode,
    output logic          iss_valid,
    output logic [KW-1:0] iss_i,
    output logic [KW-1:0] iss_j,
    output logic [KW-1:0] iss_k
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic          mode;
        logic [CW-1:0] cnt;
    } seq_s;

    seq_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.mode = accum_mode;
            end
        end else if (st_q.cnt == CW'(NOPS)) begin
            // last issue has drained through both pipeline stages
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign acc_mode  = st_q.mode;
    assign iss_valid = st_q.busy && (st_q.cnt < CW'(NOPS));
    assign iss_k     = st_q.cnt[KW-1:0];
    assign iss_j     = st_q.cnt[2*KW-1:KW];
    assign iss_i     = st_q.cnt[3*KW-1:2*KW];

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(acc_mode));
endmodule

// File: rtl/mm_mac.sv
// Two-stage MAC: stage 1 registers the product, stage 2 accumulates and writes C.
module mm_mac #(
    parameter int T    = 4,
    parameter int OPW  = 16,
    parameter int ACCW = 40,
    localparam int NEL = T * T,
    localparam int IW  = $clog2(NEL),
    localparam int PW  = 2 * OPW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [OPW-1:0] a_op,
    input  logic signed [OPW-1:0] b_op,
    input  logic                  in_first,
    input  logic                  in_last,
    input  logic [IW-1:0]         in_idx,
    input  logic                  acc_mode,
    input  logic [IW-1:0]         rd_idx,
    output logic [ACCW-1:0]       rd_data,
    output logic                  c_we
);
    typedef struct packed {
        logic                     s1_valid;
        logic                     s1_first;
        logic                     s1_last;
        logic [IW-1:0]            s1_idx;
        logic [PW-1:0]            s1_prod;
        logic [ACCW-1:0]          acc;
        logic [NEL-1:0][ACCW-1:0] cmem;
    } mac_s;

    mac_s st_d, st_q;
    logic signed [PW-1:0] mul;
    logic [ACCW-1:0]      base, prev, sum;

    always_comb begin
        mul  = a_op * b_op;
        base = acc_mode ? st_q.cmem[st_q.s1_idx] : '0;
        prev = st_q.s1_first ? base : st_q.acc;
        sum  = prev + {{(ACCW-PW){st_q.s1_prod[PW-1]}}, st_q.s1_prod};

        st_d          = st_q;
        st_d.s1_valid = in_valid;
        st_d.s1_first = in_first;
        st_d.s1_last  = in_last;
        st_d.s1_idx   = in_idx;
        st_d.s1_prod  = mul;
        if (st_q.s1_valid) begin
            st_d.acc = sum;
            if (st_q.s1_last) st_d.cmem[st_q.s1_idx] = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c_we    = st_q.s1_valid && st_q.s1_last;
    assign rd_data = st_q.cmem[rd_idx];

    // R5
    mac_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && !st_q.s1_first) |-> $past(st_q.s1_valid));
endmodule

// File: rtl/mm_tile_engine.sv
module mm_tile_engine
    import mm_pkg::*;
#(
    parameter int T    = 4,
    parameter int OPW  = 16,
    parameter int ACCW = 40,
    localparam int NEL = T * T,
    localparam int IW  = $clog2(NEL),
    localparam int WAW = $clog2(NEL / LANES),
    localparam int KW  = $clog2(T)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_valid,
    input  logic            ld_sel,
    input  logic [WAW-1:0]  ld_addr,
    input  logic [LD_W-1:0] ld_data,
    input  logic            start,
    input  logic            accum_mode,
    output logic            busy,
    output logic            done,
    input  logic [KW-1:0]   rd_row,
    input  logic [KW-1:0]   rd_col,
    output logic [ACCW-1:0] rd_data
);
    logic                  acc_mode, iss_valid, c_we;
    logic [KW-1:0]         iss_i, iss_j, iss_k;
    logic signed [OPW-1:0] a_op, b_op;
    logic                  we_a, we_b;

    assign we_a = ld_valid && !busy && !ld_sel;
    assign we_b = ld_valid && !busy &&  ld_sel;

    mm_seq #(.T(T)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .accum_mode(accum_mode),
        .busy(busy), .done(done), .acc_mode(acc_mode), .iss_valid(iss_valid),
        .iss_i(iss_i), .iss_j(iss_j), .iss_k(iss_k)
    );

    mm_opbuf #(.T(T), .OPW(OPW)) u_abuf (
        .clk(clk), .rst_n(rst_n), .we(we_a), .waddr(ld_addr), .wdata(ld_data),
        .rd_idx({iss_i, iss_k}), .rd_op(a_op)
    );

    mm_opbuf #(.T(T), .OPW(OPW)) u_bbuf (
        .clk(clk), .rst_n(rst_n), .we(we_b), .waddr(ld_addr), .wdata(ld_data),
        .rd_idx({iss_k, iss_j}), .rd_op(b_op)
    );

    mm_mac #(.T(T), .OPW(OPW), .ACCW(ACCW)) u_mac (
        .clk(clk), .rst_n(rst_n), .in_valid(iss_valid), .a_op(a_op), .b_op(b_op),
        .in_first(iss_k == '0), .in_last(iss_k == KW'(T - 1)),
        .in_idx({iss_i, iss_j}), .acc_mode(acc_mode),
        .rd_idx({rd_row, rd_col}), .rd_data(rd_data), .c_we(c_we)
    );

    // R5
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(c_we));
endmodule

// File: tb/mm_tile_engine_bench.sv
module mm_tile_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    // stimulus table: {seed_a, seed_b, accum, junk_upper_lanes}
    localparam logic [33:0] VEC [5] = '{
        {16'd7,    16'd11,   1'b0, 1'b0},
        {16'hF00D, 16'd3,    1'b0, 1'b1},
        {16'd1234, 16'hBEEF, 1'b1, 1'b0},
        {16'h8001, 16'h7FFF, 1'b1, 1'b1},
        {16'd5,    16'hFFFB, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0, ld_sel = 1'b0, start = 1'b0, accum_mode = 1'b0;
    logic [2:0]  ld_addr = '0;
    logic [63:0] ld_data = '0;
    logic [1:0]  rd_row = '0, rd_col = '0;
    logic        busy, done;
    logic [39:0] rd_data;

    int     checks = 0, failures = 0;
    int     ta [16];
    int     tb [16];
    longint cref [16];
    int     ba [64];
    int     bb [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_tile_engine u_mm_tile_engine (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .start(start), .accum_mode(accum_mode),
        .busy(busy), .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gen(input int seed, input int e);
        shortint s;
        s = shortint'(seed * (e + 3) ^ (e * 613));
        return int'(s);
    endfunction

    task automatic load_ab(input logic junk);
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 8; w++) begin
                @(negedge clk);
                ld_valid = 1'b1;
                ld_sel   = s[0];
                ld_addr  = 3'(w);
                ld_data  = {(junk ? 16'hA5C3 : 16'h0000), 16'(s == 0 ? ta[2*w+1] : tb[2*w+1]),
                            (junk ? 16'h5A3C : 16'h0000), 16'(s == 0 ? ta[2*w]   : tb[2*w])};
            end
        end
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic model(input logic acc);
        if (!acc) for (int e = 0; e < 16; e++) cref[e] = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                for (int k = 0; k < N; k++)
                    cref[i*N+j] += longint'(ta[i*N+k]) * longint'(tb[k*N+j]);
    endtask

    task automatic check_c(input string tag);
        for (int e = 0; e < 16; e++) begin
            rd_row = 2'(e / N);
            rd_col = 2'(e % N);
            #1;
            chk(tag, longint'($signed(rd_data)), cref[e]);
        end
    endtask

    // inj: 0 none, 1 load garbage mid-run (R9), 2 start pulse mid-run (R8)
    task automatic run_pass(input logic acc, input int inj);
        int cyc;
        @(negedge clk);
        start = 1'b1;
        accum_mode = acc;
        @(posedge clk);
        #1;
        start = 1'b0;
        accum_mode = 1'b0;
        chk("R6 busy after start", busy, 1);
        cyc = 0;
        while (cyc < 300) begin
            if (cyc == 10 && inj == 1) begin
                ld_valid = 1'b1; ld_sel = 1'b0; ld_addr = 3'd0; ld_data = '1;
            end
            if (cyc == 10 && inj == 2) begin
                start = 1'b1; accum_mode = 1'b1;
            end
            @(posedge clk);
            cyc++;
            #1;
            ld_valid = 1'b0; start = 1'b0; accum_mode = 1'b0;
            if (done) break;
        end
        chk("R5 done latency", cyc, 65);
        chk("R6 busy low at done", busy, 0);
        @(posedge clk);
        #1;
        chk("R7 done one cycle", done, 0);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seen;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 busy reset", busy, 0);
        chk("R10 done reset", done, 0);
        for (int e = 0; e < 16; e++) cref[e] = 0;
        check_c("R10 C reset");
        rst_n = 1'b1;

        // table-driven passes: R1, R2 (junk lanes), R3, R4 (accum), R11 (read-back)
        foreach (VEC[v]) begin
            for (int e = 0; e < 16; e++) begin
                ta[e] = gen(int'(VEC[v][33:18]), e);
                tb[e] = gen(int'(VEC[v][17:2]), e + 16);
            end
            load_ab(VEC[v][0]);
            run_pass(VEC[v][1], 0);
            model(VEC[v][1]);
            check_c(VEC[v][1] ? "R4 accumulate pass" : "R1 R2 R11 product pass");
        end

        // R3: full-scale negative by negative, then negative by positive
        for (int e = 0; e < 16; e++) begin ta[e] = -32768; tb[e] = -32768; end
        load_ab(1'b1);
        run_pass(1'b0, 0);
        model(1'b0);
        check_c("R3 full scale neg*neg");
        for (int e = 0; e < 16; e++) tb[e] = 32767;
        load_ab(1'b0);
        run_pass(1'b0, 0);
        model(1'b0);
        check_c("R3 full scale neg*pos");

        // R4: 8x8 product, C block (1,0) built from two k-tiles
        for (int e = 0; e < 64; e++) begin ba[e] = gen(977, e); bb[e] = gen(4242, e); end
        for (int kt = 0; kt < 2; kt++) begin
            for (int i = 0; i < N; i++)
                for (int k = 0; k < N; k++) begin
                    ta[i*N+k] = ba[(i+4)*8 + kt*4 + k];
                    tb[k*N+i] = bb[(kt*4+k)*8 + i];
                end
            load_ab(1'b0);
            run_pass(kt != 0, 0);
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                cref[i*N+j] = 0;
                for (int k = 0; k < 8; k++)
                    cref[i*N+j] += longint'(ba[(i+4)*8+k]) * longint'(bb[k*8+j]);
            end
        check_c("R4 tiled equals untiled");

        // R9: loads during busy are ignored, now and in the next pass
        for (int e = 0; e < 16; e++) begin ta[e] = gen(31, e); tb[e] = gen(-77, e); end
        load_ab(1'b0);
        run_pass(1'b0, 1);
        model(1'b0);
        check_c("R9 load during busy");
        run_pass(1'b0, 0);
        check_c("R9 buffer kept");

        // R8: start during busy is ignored, no extra pass follows
        run_pass(1'b0, 2);
        seen = 0;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (done || busy) seen++;
        end
        chk("R8 no extra pass", seen, 0);
        check_c("R8 C unchanged");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule